// File: doc/BRIEF.md
# Humidity Sensor Register Interface Controller

This block is the digital front of a small humidity and temperature sensor. It is an I2C target with a short register file. A host sets a go bit to launch a conversion and polls an active-low ready flag. It then fetches a two-byte result and can read an identification byte. The measurement itself is modelled by a countdown timer. When the timer expires, the block produces a fixed result pattern that depends on the conversion kind.

The block also keeps the rules that decide when its results appear and when it drops to its low-power state. A result is copied into the data registers only after the host has read the ready flag at least once since the conversion began. The register pointer is kept across a STOP. Reading the status register again and again never moves on to the data registers. After a humidity conversion, the block returns to low power only when the host follows a fixed clearing sequence. An active-low select input forces low power and makes the bus side deaf.

The bus lines are sampled by the system clock. The data line is driven through an open-drain pull-down enable.

Top module: `sens_reg_ctrl`

## Requirements
- R1: The block acknowledges a bus address byte only when its upper seven bits equal the parameter DEV_ADDR (bit 0 set means read). For any other address it leaves the data line released and ignores the bus until the next START.
- R2: Register 0x11 reads as {4'hF, REV}, with REV = 0 by default. Any register index other than 0x00 to 0x03 and 0x11 reads as 0x00.
- R3: Writing register 0x03 with bit 0 set starts a conversion when none is running. Bit 4 of the written value picks temperature (1) or humidity (0). Bit 0 of register 0x00 reads 1 until CONV_CYCLES clocks have passed, and 0 after that. Register 0x03 reads back the last value written to it.
- R4: The data registers 0x01 and 0x02 take the result only once register 0x00 has been read at least once since the start. This holds even if the conversion time has already passed. Until then they read 0x01 and 0x00.
- R5: A loaded humidity result reads RESULT_RH (high byte in 0x01, low byte in 0x02). A loaded temperature result reads RESULT_T.
- R6: The register pointer set by the first data byte of a write is kept across a STOP. A later read that sends no new pointer returns the register last addressed.
- R7: In one read transaction, further bytes from register 0x00 return register 0x00 again. A read that starts at 0x01 continues to 0x02.
- R8: low_power is 1 after reset. Starting a conversion clears it. The end of a temperature conversion sets it again when no humidity result is pending.
- R9: The end of a humidity conversion leaves low_power at 0. A temperature conversion run after it also leaves low_power at 0.
- R10: After a humidity conversion, low_power returns to 1 on the second write of 0x00 to register 0x03. This counts only once the ready flag has been read low and a loaded result byte has been read. One such write alone leaves low_power at 0.
- R11: While cs_n is high, low_power reads 1 and the block drives no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; high forces low power and mutes the bus |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 pulls the open-drain data line low |
| low_power | output | 1 | 1 while the block is in its low-power state |

## Verification
The bench waits past the full conversion time without reading the ready flag and expects 0x01 in the high data byte. A design that loads the result on the timer alone would return the real pattern. It sends a STOP and then a read without a pointer byte; a design that resets the pointer on STOP would return the status register instead of the identification byte. It reads two bytes from the status register and from the humidity high byte; an auto-increment on register 0 would show the result byte where a second status byte belongs. The power sequences check a single clear against a double clear and a temperature run after a humidity run. A design that counts one clear, or that sleeps after every conversion, changes low_power one step too early.

// File: rtl/sens_pkg.sv
// Shared types and register indices for the sensor register controller.
// Assumes byte-wide registers addressed by an 8-bit pointer.
package sens_pkg;
    typedef enum logic [2:0] {
        BUS_IDLE, BUS_ADDR, BUS_AACK, BUS_RX, BUS_WACK, BUS_TX, BUS_RACK
    } bus_st_t;

    localparam logic [7:0] REG_STATUS = 8'h00;
    localparam logic [7:0] REG_DHI    = 8'h01;
    localparam logic [7:0] REG_DLO    = 8'h02;
    localparam logic [7:0] REG_CTRL   = 8'h03;
    localparam logic [7:0] REG_IDENT  = 8'h11;
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_TEMP_BIT = 4;
endpackage

// File: rtl/sens_bus_sync.sv
// Brings scl, sda and cs_n into the clock domain and derives edge and
// START/STOP pulses. Assumes the lines change far slower than clk.
module sens_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    input  logic cs_n_raw,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic cs_q
);
    localparam int NSIG = 3;
    logic [NSIG-1:0] stage [STAGES];
    logic [NSIG-1:0] prev;
    logic [NSIG-1:0] cur;

    // synchronizer chain plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '1;
            prev <= '1;
        end else begin
            stage[0] <= {cs_n_raw, sda_raw, scl_raw};
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            prev <= stage[STAGES-1];
        end
    end

    // edge and bus condition decode
    always_comb begin
        cur       = stage[STAGES-1];
        sda_q     = cur[1];
        cs_q      = cur[2];
        scl_rise  = cur[0] & ~prev[0];
        scl_fall  = ~cur[0] & prev[0];
        start_det = cur[0] & prev[0] & prev[1] & ~cur[1];
        stop_det  = cur[0] & prev[0] & ~prev[1] & cur[1];
    end
endmodule

// File: rtl/sens_i2c_fsm.sv
// Byte-level I2C target. It matches the address, acknowledges bytes and
// shifts read data out MSB first. The first written byte is flagged as a
// pointer byte. Assumes synchronized, edge-decoded bus inputs.
module sens_i2c_fsm #(
    parameter logic [6:0] DEV_ADDR = 7'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_q,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               cs_q,
    input  logic [7:0]         rd_data,
    output logic               sda_pull,
    output logic               rd_req,
    output logic               wr_en,
    output logic               wr_ptr,
    output logic [7:0]         wr_data,
    output sens_pkg::bus_st_t  bus_st
);
    import sens_pkg::*;
    localparam int BITS = 8;
    localparam int CW   = $clog2(BITS + 1);

    logic [CW-1:0] cnt;
    logic [7:0]    shreg;
    logic [7:0]    tx;
    logic          rw;
    logic          first;
    logic          host_ack;

    assign wr_data = shreg;

    // bus protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_st <= BUS_IDLE; cnt <= '0; shreg <= '0; tx <= '0;
            rw <= 1'b0; first <= 1'b0; host_ack <= 1'b0;
            sda_pull <= 1'b0; rd_req <= 1'b0; wr_en <= 1'b0; wr_ptr <= 1'b0;
        end else begin
            rd_req <= 1'b0;
            wr_en  <= 1'b0;
            if (cs_q) begin
                bus_st <= BUS_IDLE; sda_pull <= 1'b0;
            end else if (start_det) begin
                bus_st <= BUS_ADDR; cnt <= '0; sda_pull <= 1'b0;
            end else if (stop_det) begin
                bus_st <= BUS_IDLE; sda_pull <= 1'b0;
            end else begin
                case (bus_st)
                    BUS_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_q}; cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CW'(BITS)) begin
                            cnt <= '0;
                            if (shreg[7:1] == DEV_ADDR) begin
                                bus_st <= BUS_AACK; sda_pull <= 1'b1; rw <= shreg[0];
                            end else begin
                                bus_st <= BUS_IDLE;
                            end
                        end
                    end
                    BUS_AACK: if (scl_fall) begin
                        if (rw) begin
                            bus_st <= BUS_TX; tx <= rd_data;
                            sda_pull <= ~rd_data[7]; rd_req <= 1'b1;
                        end else begin
                            bus_st <= BUS_RX; sda_pull <= 1'b0; first <= 1'b1;
                        end
                    end
                    BUS_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_q}; cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == CW'(BITS)) begin
                            cnt <= '0; bus_st <= BUS_WACK; sda_pull <= 1'b1;
                            wr_en <= 1'b1; wr_ptr <= first; first <= 1'b0;
                        end
                    end
                    BUS_WACK: if (scl_fall) begin
                        bus_st <= BUS_RX; sda_pull <= 1'b0;
                    end
                    BUS_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == CW'(BITS)) begin
                                cnt <= '0; bus_st <= BUS_RACK; sda_pull <= 1'b0;
                            end else begin
                                tx <= {tx[6:0], 1'b0}; sda_pull <= ~tx[6];
                            end
                        end
                    end
                    BUS_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_q;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                bus_st <= BUS_TX; tx <= rd_data;
                                sda_pull <= ~rd_data[7]; rd_req <= 1'b1;
                            end else begin
                                bus_st <= BUS_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sens_regfile.sv
// Register file, conversion timer stub and power-state tracking.
// Assumes rd_req and wr_en are single-cycle pulses that never coincide.
module sens_regfile #(
    parameter int          CONV_CYCLES = 4000,
    parameter logic [15:0] RESULT_RH   = 16'h5A3C,
    parameter logic [15:0] RESULT_T    = 16'h1F80,
    parameter logic [3:0]  REV         = 4'h0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req,
    input  logic       wr_en,
    input  logic       wr_ptr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       busy,
    output logic       standby
);
    import sens_pkg::*;
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic [7:0]    ctrl, dhi, dlo;
    logic          done, is_temp, rdy_seen, loaded;
    logic          rh_pend, polled, res_read;
    logic [1:0]    clr_cnt;

    // read multiplexer addressed by the pointer
    always_comb begin
        case (ptr)
            REG_STATUS: rd_data = {7'b0, ~done};
            REG_DHI:    rd_data = dhi;
            REG_DLO:    rd_data = dlo;
            REG_CTRL:   rd_data = ctrl;
            REG_IDENT:  rd_data = {4'hF, REV};
            default:    rd_data = 8'h00;
        endcase
    end

    // conversion, result load, pointer and standby bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0; ctrl <= '0; dhi <= '0; dlo <= '0; cnt <= '0;
            busy <= 1'b0; done <= 1'b0; is_temp <= 1'b0; rdy_seen <= 1'b0;
            loaded <= 1'b0; rh_pend <= 1'b0; polled <= 1'b0; res_read <= 1'b0;
            clr_cnt <= '0; standby <= 1'b1;
        end else begin
            if (busy) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0; done <= 1'b1;
                    if (is_temp) standby <= ~rh_pend;
                    else         rh_pend <= 1'b1;
                end
            end
            if (done && rdy_seen && !loaded) begin
                loaded <= 1'b1;
                {dhi, dlo} <= is_temp ? RESULT_T : RESULT_RH;
            end
            if (rd_req) begin
                if (ptr == REG_STATUS) begin
                    if (busy || done) rdy_seen <= 1'b1;
                    if (done) polled <= 1'b1;
                end
                if ((ptr == REG_DHI || ptr == REG_DLO) && loaded) res_read <= 1'b1;
                if (ptr == REG_DHI) ptr <= REG_DLO;
            end
            if (wr_en) begin
                if (wr_ptr) begin
                    ptr <= wr_data;
                end else if (ptr == REG_CTRL) begin
                    ctrl <= wr_data;
                    if (wr_data[CTRL_GO_BIT] && !busy) begin
                        busy <= 1'b1; done <= 1'b0; cnt <= CW'(CONV_CYCLES);
                        is_temp <= wr_data[CTRL_TEMP_BIT]; rdy_seen <= 1'b0;
                        loaded <= 1'b0; dhi <= 8'h01; dlo <= 8'h00;
                        standby <= 1'b0; polled <= 1'b0; res_read <= 1'b0;
                        clr_cnt <= '0;
                    end else if (wr_data == 8'h00 && rh_pend && polled && res_read) begin
                        if (clr_cnt == 2'd1) begin
                            standby <= 1'b1; rh_pend <= 1'b0; clr_cnt <= '0;
                        end else begin
                            clr_cnt <= clr_cnt + 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sens_reg_ctrl.sv
// Top of the sensor register interface controller: bus synchronizer,
// I2C target and register file. Assumes cs_n is tied low when unused.
module sens_reg_ctrl #(
    parameter logic [6:0]  DEV_ADDR    = 7'h40,
    parameter int          SYNC_STAGES = 2,
    parameter int          CONV_CYCLES = 4000,
    parameter logic [15:0] RESULT_RH   = 16'h5A3C,
    parameter logic [15:0] RESULT_T    = 16'h1F80,
    parameter logic [3:0]  REV         = 4'h0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull,
    output logic low_power
);
    logic              sda_q, scl_rise, scl_fall, start_det, stop_det, cs_q;
    logic              rd_req, wr_en, wr_ptr, busy, standby_q;
    logic [7:0]        wr_data, rd_data, ptr;
    sens_pkg::bus_st_t bus_st;

    sens_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
        .cs_n_raw(cs_n), .sda_q(sda_q), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .cs_q(cs_q)
    );

    sens_i2c_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_q(sda_q), .start_det(start_det), .stop_det(stop_det),
        .cs_q(cs_q), .rd_data(rd_data), .sda_pull(sda_pull),
        .rd_req(rd_req), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(wr_data), .bus_st(bus_st)
    );

    sens_regfile #(
        .CONV_CYCLES(CONV_CYCLES), .RESULT_RH(RESULT_RH),
        .RESULT_T(RESULT_T), .REV(REV)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_en(wr_en),
        .wr_ptr(wr_ptr), .wr_data(wr_data), .rd_data(rd_data),
        .ptr(ptr), .busy(busy), .standby(standby_q)
    );

    // select high overrides the tracked power state
    assign low_power = standby_q | cs_q;
endmodule

// File: rtl/sens_reg_ctrl_chk.sv
// Property checker for sens_reg_ctrl, attached by bind below.
module sens_reg_ctrl_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cs_q,
    input logic              sda_pull,
    input logic              low_power,
    input logic              busy,
    input logic              standby_q,
    input logic              stop_det,
    input logic [7:0]        ptr,
    input sens_pkg::bus_st_t bus_st
);
    import sens_pkg::*;

    AST_CS_MUTES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !sda_pull); // R11

    AST_CS_FORCES_LP: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) |-> low_power); // R11

    AST_RUN_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !standby_q); // R8

    AST_PTR_KEPT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> $stable(ptr)); // R6

    AST_DRIVE_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (bus_st == BUS_AACK || bus_st == BUS_WACK || bus_st == BUS_TX)); // R1
endmodule

bind sens_reg_ctrl sens_reg_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_q(cs_q), .sda_pull(sda_pull),
    .low_power(low_power), .busy(busy), .standby_q(standby_q),
    .stop_det(stop_det), .ptr(ptr), .bus_st(bus_st)
);

// File: tb/tb_sens_reg_ctrl.sv
// Self-checking bench: a bit-banged bus master with directed sequences
// and seeded random address sweeps.
module tb_sens_reg_ctrl;
    localparam int          CLK_PERIOD = 10;
    localparam int          Q          = 8;
    localparam logic [6:0]  DEV        = 7'h40;
    localparam int          CONV       = 4000;
    localparam logic [15:0] RH_VAL     = 16'h5A3C;
    localparam logic [15:0] T_VAL      = 16'h1F80;
    localparam logic [3:0]  REV        = 4'h0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, low_power;
    wire  sda_line = sda_m & ~sda_pull;
    int   n_cmp = 0;
    int   n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sens_reg_ctrl #(.DEV_ADDR(DEV), .CONV_CYCLES(CONV), .RESULT_RH(RH_VAL),
                    .RESULT_T(T_VAL), .REV(REV)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull(sda_pull), .low_power(low_power)
    );

    function automatic logic [7:0] exp_static(input logic [7:0] a);
        return (a == 8'h11) ? {4'hF, REV} : 8'h00;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line;
        tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic x;
        for (int i = 7; i >= 0; i--) begin get_bit(x); v[i] = x; end
        put_bit(~give_ack);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
        logic k;
        bus_start(); send_byte({DEV, 1'b0}, k); send_byte(a, k);
        send_byte(v, k); bus_stop();
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic k;
        bus_start(); send_byte({DEV, 1'b0}, k); send_byte(a, k); bus_stop();
    endtask

    task automatic rd_cur(output logic [7:0] v);
        logic k;
        bus_start(); send_byte({DEV, 1'b1}, k); recv_byte(1'b0, v); bus_stop();
    endtask

    task automatic rd_pair(output logic [7:0] v0, output logic [7:0] v1);
        logic k;
        bus_start(); send_byte({DEV, 1'b1}, k);
        recv_byte(1'b1, v0); recv_byte(1'b0, v1); bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
        set_ptr(a); rd_cur(v);
    endtask

    task automatic poll_ready(input string req);
        logic [7:0] s;
        s = 8'h01;
        for (int i = 0; i < 12 && s[0]; i++) rd_reg(8'h00, s);
        chk(req, s, 8'h00);
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v, w;
        logic       k;
        void'($urandom(32'd7015));
        tick(4); rst_n = 1'b1; tick(4);
        chk("R8 reset low_power", low_power, 1);
        chk("R1 reset bus released", sda_pull, 0);

        // R2 identification and unmapped registers
        rd_reg(8'h11, v); chk("R2 ident", v, exp_static(8'h11));
        for (int i = 0; i < 8; i++) begin
            logic [7:0] a;
            a = 8'($urandom_range(4, 255));
            if (a == 8'h11) a = 8'h20;
            rd_reg(a, v); chk("R2 unmapped", v, exp_static(a));
        end

        // R1 foreign addresses are not acknowledged
        for (int i = 0; i < 6; i++) begin
            logic [6:0] a;
            a = 7'($urandom_range(0, 127));
            if (a == DEV) a = DEV ^ 7'h01;
            bus_start(); send_byte({a, 1'($urandom_range(0, 1))}, k); bus_stop();
            chk("R1 foreign address nack", k, 0);
        end
        bus_start(); send_byte({DEV, 1'b0}, k); bus_stop();
        chk("R1 own address ack", k, 1);

        // R4 result withheld until ready flag read
        wr_reg(8'h03, 8'h01);
        chk("R8 start leaves low power", low_power, 0);
        tick(CONV + 200);
        rd_reg(8'h01, v); chk("R4 high byte before poll", v, 8'h01);
        rd_reg(8'h02, v); chk("R4 low byte before poll", v, 8'h00);
        rd_reg(8'h00, v); chk("R3 ready after time", v, 8'h00);
        set_ptr(8'h01); rd_pair(v, w);
        chk("R5 humidity high", v, RH_VAL[15:8]);
        chk("R7 humidity low follows", w, RH_VAL[7:0]);
        chk("R9 humidity end stays awake", low_power, 0);

        // R3 busy flag then temperature after humidity (R9)
        wr_reg(8'h03, 8'h11);
        rd_reg(8'h00, v); chk("R3 busy reads one", v, 8'h01);
        rd_reg(8'h03, v); chk("R3 ctrl readback", v, 8'h11);
        poll_ready("R3 ready after poll");
        set_ptr(8'h01); rd_pair(v, w);
        chk("R5 temp high", v, T_VAL[15:8]);
        chk("R5 temp low", w, T_VAL[7:0]);
        chk("R9 temp after humidity awake", low_power, 0);

        // R10 double clear
        wr_reg(8'h03, 8'h00); chk("R10 one clear awake", low_power, 0);
        wr_reg(8'h03, 8'h00); chk("R10 two clears sleep", low_power, 1);

        // R8 temperature alone returns to low power
        wr_reg(8'h03, 8'h11); chk("R8 temp start awake", low_power, 0);
        poll_ready("R8 temp ready");
        chk("R8 temp end sleeps", low_power, 1);

        // R10 single clear must not suffice
        wr_reg(8'h03, 8'h01);
        poll_ready("R10 humidity ready");
        rd_reg(8'h01, v); chk("R10 result read", v, RH_VAL[15:8]);
        wr_reg(8'h03, 8'h00); chk("R10 single clear", low_power, 0);
        wr_reg(8'h03, 8'h00); chk("R10 second clear", low_power, 1);

        // R6 pointer survives stop
        set_ptr(8'h11); rd_cur(v); chk("R6 pointer after stop", v, 8'h11 ^ 8'h11 ^ {4'hF, REV});
        rd_cur(v); chk("R6 pointer reused", v, {4'hF, REV});

        // R7 status does not advance
        set_ptr(8'h00); rd_pair(v, w);
        chk("R7 status first", v, 8'h00);
        chk("R7 status repeated", w, 8'h00);

        // R11 chip select high
        cs_n = 1'b1; tick(10);
        chk("R11 low power forced", low_power, 1);
        bus_start(); send_byte({DEV, 1'b1}, k); bus_stop();
        chk("R11 no ack while deselected", k, 0);
        cs_n = 1'b0; tick(10);
        rd_reg(8'h11, v); chk("R11 bus back after select", v, {4'hF, REV});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule